// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is one 32-pin general-purpose I/O bank behind a small 32-bit register interface. Software drives pins through an output data word and an output-enable word, samples them through a synchronized input word, and sets up one pull resistor per pin as plain control bits that go to the pad ring. Each pin can raise an interrupt. The sense mode is chosen per pin by three independent bits: level or edge, dual-edge, and polarity.

Detected events are latched into a raw status word. A mask word gates raw status into a masked status word, and the OR of the masked bits drives a single registered interrupt line. Status bits are cleared one at a time by writing ones to a clear word. The bus has a valid strobe, a write flag, a byte address, write data and read data. A read returns data in the same cycle. A write takes effect at the next clock edge.

Top module: `gpio_bank`

## Requirements
- R1: Word-aligned registers sit at these byte offsets: 0x00 synchronized input, 0x04 output data, 0x08 output enable, 0x0C sense type (1 = level, 0 = edge), 0x10 dual-edge, 0x14 polarity (1 = rising/high, 0 = falling/low), 0x18 mask (1 = enabled), 0x1C raw status, 0x20 masked status, 0x24 clear, 0x34 pull select (1 = up, 0 = down), 0x38 pull enable. Bit i of each register belongs to pin i. Reads of any other offset, of a misaligned address, or of the clear word return zero, and writes to read-only words have no effect.
- R2: pin_out equals the output data register and pin_oe equals the output enable register, with both updating one clock edge after the write.
- R3: The input word shows each pin through two flops, so a pin change becomes readable after the second rising edge.
- R4: With type 0 and dual-edge 0, a pin latches raw status on a rising edge of its synchronized value when polarity is 1, and on a falling edge when polarity is 0.
- R5: With type 0 and dual-edge 1, both edges latch raw status whatever the polarity bit holds.
- R6: With type 1, raw status is set on every cycle that the synchronized pin is at its active level, so a clear during that level leaves the bit set.
- R7: Masked status reads as raw status ANDed with the mask.
- R8: Writing the clear word drops only the raw bits written as 1. If an edge is latched in the same cycle as its clear, the bit stays set.
- R9: irq is the registered OR of all masked status bits, so it follows the masked status one cycle later.
- R10: pull_en and pull_up output the pull enable and pull select registers.
- R11: After reset, every register, every output and the interrupt line are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| pin_in | input | NPIN | Asynchronous pin levels |
| pin_out | output | NPIN | Output data to pads |
| pin_oe | output | NPIN | Output enable to pads |
| pull_en | output | NPIN | Pull resistor enable per pin |
| pull_up | output | NPIN | Pull direction per pin, 1 = up |
| irq | output | 1 | Combined interrupt |

## Verification
Directed sequences cover the different sense modes one at a time. A single rising edge under each polarity separates the rising and falling selection. A rise and then a fall with polarity 0 and dual-edge set shows that the polarity bit is ignored. A held low level that is cleared shows that a level re-sets status. A clear that lands on the same edge as a fresh event shows which one wins, and a clear of one of two set bits shows that the clear is per bit. Random pin toggling against random sense, mask and clear settings, with every register read and the interrupt compared against a cycle model, catches interactions between mode bits that the directed cases miss.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pull_en,
  output logic [NPIN-1:0]   pull_up,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_DIN  = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_DOUT = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_OE   = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_TYPE = WORD_W'(3);
  localparam logic [WORD_W-1:0] W_DUAL = WORD_W'(4);
  localparam logic [WORD_W-1:0] W_POL  = WORD_W'(5);
  localparam logic [WORD_W-1:0] W_MASK = WORD_W'(6);
  localparam logic [WORD_W-1:0] W_RAW  = WORD_W'(7);
  localparam logic [WORD_W-1:0] W_MST  = WORD_W'(8);
  localparam logic [WORD_W-1:0] W_CLR  = WORD_W'(9);
  localparam logic [WORD_W-1:0] W_PSEL = WORD_W'(13);
  localparam logic [WORD_W-1:0] W_PEN  = WORD_W'(14);

  logic [WORD_W-1:0] word;
  logic              aligned, wr, rd;
  logic [NPIN-1:0]   wval;
  logic [NPIN-1:0]   sense_type, sense_dual, sense_pol, int_mask, raw_stat;
  logic [NPIN-1:0]   sync_a, sync_b, sync_prev;
  logic [NPIN-1:0]   rise, fall, edge_hit, level_hit, hit, clr, masked;
  logic [NPIN-1:0]   rd_val;
  logic              irq_q;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr      = bus_valid & bus_write & aligned;
  assign rd      = bus_valid & ~bus_write & aligned;
  assign wval    = bus_wdata[NPIN-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a    <= '0;
      sync_b    <= '0;
      sync_prev <= '0;
    end else begin
      sync_a    <= pin_in;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_out    <= '0;
      pin_oe     <= '0;
      sense_type <= '0;
      sense_dual <= '0;
      sense_pol  <= '0;
      int_mask   <= '0;
      pull_up    <= '0;
      pull_en    <= '0;
    end else if (wr) begin
      case (word)
        W_DOUT:  pin_out    <= wval;
        W_OE:    pin_oe     <= wval;
        W_TYPE:  sense_type <= wval;
        W_DUAL:  sense_dual <= wval;
        W_POL:   sense_pol  <= wval;
        W_MASK:  int_mask   <= wval;
        W_PSEL:  pull_up    <= wval;
        W_PEN:   pull_en    <= wval;
        default: ;
      endcase
    end
  end

  assign rise      = sync_b & ~sync_prev;
  assign fall      = ~sync_b & sync_prev;
  assign edge_hit  = (sense_dual & (rise | fall)) |
                     (~sense_dual & ((sense_pol & rise) | (~sense_pol & fall)));
  assign level_hit = ~(sync_b ^ sense_pol);
  assign hit       = (sense_type & level_hit) | (~sense_type & edge_hit);
  assign clr       = (wr && word == W_CLR) ? wval : '0;
  assign masked    = raw_stat & int_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_stat <= '0;
      irq_q    <= 1'b0;
    end else begin
      raw_stat <= hit | (raw_stat & ~clr);
      irq_q    <= |masked;
    end
  end

  assign irq = irq_q;

  always_comb begin
    case (word)
      W_DIN:   rd_val = sync_b;
      W_DOUT:  rd_val = pin_out;
      W_OE:    rd_val = pin_oe;
      W_TYPE:  rd_val = sense_type;
      W_DUAL:  rd_val = sense_dual;
      W_POL:   rd_val = sense_pol;
      W_MASK:  rd_val = int_mask;
      W_RAW:   rd_val = raw_stat;
      W_MST:   rd_val = masked;
      W_PSEL:  rd_val = pull_up;
      W_PEN:   rd_val = pull_en;
      default: rd_val = '0;
    endcase
  end

  assign bus_rdata = rd ? 32'(rd_val) : 32'd0;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pull_en,
  input logic [NPIN-1:0]   pull_up,
  input logic              irq,
  input logic [NPIN-1:0]   raw_stat,
  input logic [NPIN-1:0]   int_mask,
  input logic [NPIN-1:0]   sense_type,
  input logic [NPIN-1:0]   sense_pol,
  input logic [NPIN-1:0]   sync_b
);
  logic            wr_any, clr_wr, dout_wr;
  logic [NPIN-1:0] lvl_active;

  assign wr_any     = bus_valid && bus_write && bus_addr[1:0] == 2'b00;
  assign clr_wr     = wr_any && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(9);
  assign dout_wr    = wr_any && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1);
  assign lvl_active = sense_type & ~(sync_b ^ sense_pol);

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_stat & int_mask)) |=> irq); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(raw_stat & int_mask)) |=> !irq); // R9
  AST_DOUT_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dout_wr |=> pin_out == $past(bus_wdata[NPIN-1:0])); // R2
  AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (raw_stat & $past(raw_stat)) == $past(raw_stat)); // R8
  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_active) |=> (raw_stat & $past(lvl_active)) == $past(lvl_active)); // R6
  AST_PULL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> $stable(pull_en) && $stable(pull_up)); // R10
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
  .pull_en(pull_en), .pull_up(pull_up), .irq(irq), .raw_stat(raw_stat),
  .int_mask(int_mask), .sense_type(sense_type), .sense_pol(sense_pol),
  .sync_b(sync_b));

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins = '0;
  logic [31:0] pin_out, pin_oe, pull_en, pull_up;
  logic        irq;
  int checks = 0, errors = 0;
  logic cmp_on = 1'b0;

  always #4 clk = ~clk;

  gpio_bank dut_i (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en), .pull_up(pull_up), .irq(irq));

  logic [31:0] m_a, m_b, m_p, m_raw, m_dout, m_oe, m_typ, m_dual, m_pol, m_msk, m_psel, m_pen;
  logic        m_irq;

  always @(posedge clk) begin
    logic [31:0] r, f, eh, lh, h, c;
    if (!rst_n) begin
      {m_a, m_b, m_p, m_raw, m_dout, m_oe} <= '0;
      {m_typ, m_dual, m_pol, m_msk, m_psel, m_pen} <= '0;
      m_irq <= 1'b0;
    end else begin
      r  = m_b & ~m_p;
      f  = ~m_b & m_p;
      eh = (m_dual & (r | f)) | (~m_dual & ((m_pol & r) | (~m_pol & f)));
      lh = m_pol ~^ m_b;
      h  = (m_typ & lh) | (~m_typ & eh);
      c  = (bus_valid && bus_write && bus_addr == 9'h24) ? bus_wdata : 32'd0;
      m_a <= pins; m_b <= m_a; m_p <= m_b;
      m_raw <= h | (m_raw & ~c);
      m_irq <= |(m_raw & m_msk);
      if (bus_valid && bus_write)
        case (bus_addr)
          9'h04: m_dout <= bus_wdata;
          9'h08: m_oe   <= bus_wdata;
          9'h0C: m_typ  <= bus_wdata;
          9'h10: m_dual <= bus_wdata;
          9'h14: m_pol  <= bus_wdata;
          9'h18: m_msk  <= bus_wdata;
          9'h34: m_psel <= bus_wdata;
          9'h38: m_pen  <= bus_wdata;
          default: ;
        endcase
    end
  end

  function automatic logic [31:0] exp_read(input logic [8:0] a);
    case (a)
      9'h00: return m_b;
      9'h04: return m_dout;
      9'h08: return m_oe;
      9'h0C: return m_typ;
      9'h10: return m_dual;
      9'h14: return m_pol;
      9'h18: return m_msk;
      9'h1C: return m_raw;
      9'h20: return m_raw & m_msk;
      9'h34: return m_psel;
      9'h38: return m_pen;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [8:0] a);
    case (a)
      9'h00: return "R3";
      9'h04, 9'h08: return "R2";
      9'h0C, 9'h10, 9'h14: return "R4";
      9'h1C: return "R5";
      9'h20: return "R7";
      9'h34, 9'h38: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    v = bus_rdata;
    chk(tag_of(a), v, exp_read(a));
    bus_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    #2;
    if (cmp_on) begin
      chk("R9",  {31'd0, irq}, {31'd0, m_irq});
      chk("R2",  pin_out, m_dout);
      chk("R2",  pin_oe, m_oe);
      chk("R10", pull_en, m_pen);
      chk("R10", pull_up, m_psel);
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7341));
    tick(5);
    rst_n = 1'b1;
    tick(1);
    cmp_on = 1'b1;
    for (int a = 0; a < 16; a++) begin
      rd(9'(a * 4), v);
      chk("R11", v, 32'd0);
    end
    rd(9'h02, v); chk("R1", v, 32'd0);
    chk("R11", {31'd0, irq}, 32'd0);

    wr(9'h04, 32'hA5A5_0F0F); wr(9'h08, 32'hFFFF_0000);
    wr(9'h34, 32'h0000_00F0); wr(9'h38, 32'h0000_0FF0);
    chk("R2", pin_out, 32'hA5A5_0F0F);
    chk("R10", pull_up, 32'h0000_00F0);
    wr(9'h1C, 32'hFFFF_FFFF); rd(9'h1C, v); chk("R1", v, 32'd0);

    pins[7] = 1'b1; tick(1); rd(9'h00, v); chk("R3", v & 32'h80, 32'h0);
    tick(1); rd(9'h00, v); chk("R3", v & 32'h80, 32'h80);
    rd(9'h1C, v); chk("R4", v & 32'h80, 32'h0);

    wr(9'h14, 32'h0000_0001); wr(9'h18, 32'h0000_000F);
    pins[0] = 1'b1; tick(3);
    rd(9'h1C, v); chk("R4", v & 32'h1, 32'h1);
    rd(9'h20, v); chk("R7", v & 32'h1, 32'h1);
    tick(1); chk("R9", {31'd0, irq}, 32'd1);
    wr(9'h24, 32'h1); rd(9'h1C, v); chk("R8", v & 32'h1, 32'h0);
    pins[0] = 1'b0; tick(3); rd(9'h1C, v); chk("R4", v & 32'h1, 32'h0);

    wr(9'h10, 32'h0000_0002);
    pins[1] = 1'b1; tick(3); rd(9'h1C, v); chk("R5", v & 32'h2, 32'h2);
    wr(9'h24, 32'h2);
    pins[1] = 1'b0; tick(3); rd(9'h1C, v); chk("R5", v & 32'h2, 32'h2);

    pins[0] = 1'b1; tick(3);
    wr(9'h24, 32'h1); rd(9'h1C, v); chk("R8", v & 32'h3, 32'h2);
    wr(9'h24, 32'h2);
    pins[1] = 1'b1; tick(2); wr(9'h24, 32'h2);
    rd(9'h1C, v); chk("R8", v & 32'h2, 32'h2);

    wr(9'h0C, 32'h0000_0004); tick(1);
    rd(9'h1C, v); chk("R6", v & 32'h4, 32'h4);
    wr(9'h24, 32'h4); rd(9'h1C, v); chk("R6", v & 32'h4, 32'h4);
    pins[2] = 1'b1; tick(3); wr(9'h24, 32'h4);
    rd(9'h1C, v); chk("R6", v & 32'h4, 32'h0);

    for (int i = 0; i < 6000; i++) begin
      pins = pins ^ ($urandom & $urandom & $urandom);
      case ($urandom % 8)
        0: wr(9'(4 * (1 + $urandom % 8)), $urandom);
        1: wr(9'h24, $urandom);
        2: wr(9'(4 * (13 + $urandom % 2)), $urandom);
        default: tick(1);
      endcase
      rd(9'(4 * ($urandom % 16)), v);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule